// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM interface and, once reset is released, drives the command sequence that a DDR SDRAM needs before normal traffic may start. It owns the clock-enable, chip-select, row strobe, column strobe, write-enable, bank-address and address pins for the whole sequence. When the sequence ends it raises a done flag, and a traffic controller then takes over the bus.

After a long stable period with clock enable high and NOP on the bus, the block issues the following commands in order: a precharge of all banks, a write to the extended mode register that keeps the DLL enabled, and a base mode-register write that resets the DLL. Then it issues a second precharge-all, a parameterised number of auto-refreshes, and a last base mode-register write with the DLL-reset bit clear. Every command lasts one cycle and is followed by its own wait of NOP cycles. Each wait length and the number of refreshes are parameters. The operating mode (burst length, burst type, CAS latency) and the extended-register operand come from inputs. Their values are taken in the cycle the command is on the bus.

Top module: `ddr_init_seq`

## Requirements
- R1: While rst_ni is low: cke_o=0, the bus carries NOP (cs_no=0, ras_no=1, cas_no=1, we_no=1), ba_o=0, addr_o=0 and done_o=0.
- R2: From the first clock edge after reset release, cke_o is 1. The bus then carries NOP for exactly STABLE_CYC cycles before the first command.
- R3: Each command is on the bus for exactly one cycle. It is followed by exactly that step's wait count of NOP cycles, and the next command comes in the cycle after.
- R4: The first command is a precharge of all banks: cs_no=0, ras_no=0, cas_no=1, we_no=0, addr_o bit 10 = 1, all other address bits 0, ba_o=0. Its wait is T_RP.
- R5: The second command writes the extended mode register: all four strobes 0, ba_o=2'b01 (bit 0 is BA0). addr_o bit 0 = 0 (DLL enabled) and addr_o[12:1] = ext_mode_i. Its wait is T_MRD.
- R6: The third command writes the base mode register with DLL reset: all four strobes 0, ba_o=0. The address fields are A2..A0 = burst_len_i, A3 = burst_type_i, A6..A4 = cas_lat_i, A7 = 0, A8 = 1, A12..A9 = 0. Its wait is T_MRD.
- R7: The fourth command is a second precharge-all, encoded as in R4, with wait T_RP.
- R8: N_REF auto-refresh commands follow (cs_no=0, ras_no=0, cas_no=0, we_no=1, ba_o=0, addr_o=0), each with wait T_RFC.
- R9: The last command is a base mode-register write encoded as in R6 but with A8 = 0. It is followed by T_FINAL NOP cycles, after which done_o rises.
- R10: Once done_o is high it stays high, with cke_o high and NOP on the bus, until the next reset. A reset in mid-sequence restarts everything from R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| burst_len_i | input | 3 | Burst length code for mode word A2..A0 |
| burst_type_i | input | 1 | Burst type for mode word A3 |
| cas_lat_i | input | 3 | CAS latency code for mode word A6..A4 |
| ext_mode_i | input | ADDR_W-1 | Extended-register operand for A12..A1 |
| cke_o | output | 1 | Clock enable |
| cs_no | output | 1 | Chip select, active low |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe, active low |
| we_no | output | 1 | Write enable, active low |
| ba_o | output | BA_W | Bank address |
| addr_o | output | ADDR_W | Address / operand |
| done_o | output | 1 | Initialization complete |

## Verification
The bench compares every cycle of the sequence against an expected trace. It builds that trace arithmetically from the wait parameters, using distinct wait lengths and three refreshes so that a wrong gap or a missing command shifts every later slot. This is repeated over several mode-input patterns whose burst-length, type and latency codes differ in every field, so a swapped or misplaced field in either mode write shows up. The extended operand always has its low bit set at the input, which exposes a failure to force the DLL-enable bit. One run is cut short by a reset in mid-sequence, and a run that reaches done is held for many cycles to show that the flag and the idle bus persist.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  typedef enum logic [2:0] {
    ST_PWR, ST_PREA1, ST_EMRS, ST_MRS_DLL, ST_PREA2, ST_REF, ST_MRS_FIN, ST_DONE
  } step_e;

  // cs_n, ras_n, cas_n, we_n
  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_pins_t;

  localparam cmd_pins_t PINS_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam cmd_pins_t PINS_PRE = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
  localparam cmd_pins_t PINS_REF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
  localparam cmd_pins_t PINS_MRS = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
  parameter int CNT_W   = 16,
  parameter int RST_VAL = 100
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= CNT_W'(RST_VAL);
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  a_r3_count_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  a_r3_hold_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && expired_o) |=> expired_o);

endmodule

// File: rtl/ddr_init_fsm.sv
module ddr_init_fsm
  import ddr_init_pkg::*;
#(
  parameter int T_RP    = 3,
  parameter int T_MRD   = 2,
  parameter int T_RFC   = 10,
  parameter int T_FINAL = 200,
  parameter int N_REF   = 2,
  parameter int CNT_W   = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             expired_i,
  output step_e            step_o,
  output logic             in_cmd_o,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic             done_o
);

  localparam int RW = $clog2(N_REF + 1);

  step_e         step_q, step_d;
  logic          in_cmd_q;
  logic [RW-1:0] ref_q;
  logic          last_ref;

  assign last_ref = (ref_q == RW'(N_REF - 1));

  always_comb begin
    unique case (step_q)
      ST_PWR:     step_d = ST_PREA1;
      ST_PREA1:   step_d = ST_EMRS;
      ST_EMRS:    step_d = ST_MRS_DLL;
      ST_MRS_DLL: step_d = ST_PREA2;
      ST_PREA2:   step_d = ST_REF;
      ST_REF:     step_d = last_ref ? ST_MRS_FIN : ST_REF;
      ST_MRS_FIN: step_d = ST_DONE;
      default:    step_d = ST_DONE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q   <= ST_PWR;
      in_cmd_q <= 1'b0;
      ref_q    <= '0;
    end else if (in_cmd_q) begin
      in_cmd_q <= 1'b0;
    end else if (step_q != ST_DONE && expired_i) begin
      step_q   <= step_d;
      in_cmd_q <= (step_d != ST_DONE);
      if (step_q == ST_REF) ref_q <= ref_q + 1'b1;
    end
  end

  always_comb begin
    unique case (step_q)
      ST_PREA1, ST_PREA2:   load_val_o = CNT_W'(T_RP - 1);
      ST_EMRS, ST_MRS_DLL:  load_val_o = CNT_W'(T_MRD - 1);
      ST_REF:               load_val_o = CNT_W'(T_RFC - 1);
      ST_MRS_FIN:           load_val_o = CNT_W'(T_FINAL - 1);
      default:              load_val_o = '0;
    endcase
  end

  assign step_o   = step_q;
  assign in_cmd_o = in_cmd_q;
  assign load_o   = in_cmd_q;
  assign done_o   = (step_q == ST_DONE);

  a_r10_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);

  a_r8_ref_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_q <= RW'(N_REF));

  a_r9_refs_before_final: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q == ST_MRS_FIN) |-> (ref_q == RW'(N_REF)));

endmodule

// File: rtl/ddr_init_cmd_enc.sv
module ddr_init_cmd_enc
  import ddr_init_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2
) (
  input  step_e             step_i,
  input  logic              in_cmd_i,
  input  logic [2:0]        burst_len_i,
  input  logic              burst_type_i,
  input  logic [2:0]        cas_lat_i,
  input  logic [ADDR_W-2:0] ext_mode_i,
  output cmd_pins_t         pins_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o
);

  function automatic logic [ADDR_W-1:0] mode_word(input logic dll_rst);
    logic [ADDR_W-1:0] w;
    w      = '0;
    w[2:0] = burst_len_i;
    w[3]   = burst_type_i;
    w[6:4] = cas_lat_i;
    w[8]   = dll_rst;
    return w;
  endfunction

  always_comb begin
    pins_o = PINS_NOP;
    ba_o   = '0;
    addr_o = '0;
    if (in_cmd_i) begin
      unique case (step_i)
        ST_PREA1, ST_PREA2: begin
          pins_o     = PINS_PRE;
          addr_o[10] = 1'b1;   // all banks
        end
        ST_EMRS: begin
          pins_o = PINS_MRS;
          ba_o   = BA_W'(1);
          addr_o = {ext_mode_i, 1'b0};  // DLL kept enabled
        end
        ST_MRS_DLL: begin
          pins_o = PINS_MRS;
          addr_o = mode_word(1'b1);
        end
        ST_MRS_FIN: begin
          pins_o = PINS_MRS;
          addr_o = mode_word(1'b0);
        end
        ST_REF:  pins_o = PINS_REF;
        default: pins_o = PINS_NOP;
      endcase
    end
  end

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int STABLE_CYC = 20000,
  parameter int T_RP       = 3,
  parameter int T_MRD      = 2,
  parameter int T_RFC      = 10,
  parameter int T_FINAL    = 200,
  parameter int N_REF      = 2,
  parameter int ADDR_W     = 13,
  parameter int BA_W       = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        burst_len_i,
  input  logic              burst_type_i,
  input  logic [2:0]        cas_lat_i,
  input  logic [ADDR_W-2:0] ext_mode_i,
  output logic              cke_o,
  output logic              cs_no,
  output logic              ras_no,
  output logic              cas_no,
  output logic              we_no,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o
);

  localparam int M1    = (STABLE_CYC > T_FINAL) ? STABLE_CYC : T_FINAL;
  localparam int M2    = (T_RFC > T_RP) ? T_RFC : T_RP;
  localparam int M3    = (M2 > T_MRD) ? M2 : T_MRD;
  localparam int MAX_W = (M1 > M3) ? M1 : M3;
  localparam int CNT_W = $clog2(MAX_W + 1);

  step_e            step;
  logic             in_cmd, load, expired, cke_q;
  logic [CNT_W-1:0] load_val;
  cmd_pins_t        pins;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cke_q <= 1'b0;
    else         cke_q <= 1'b1;
  end

  ddr_init_timer #(.CNT_W(CNT_W), .RST_VAL(STABLE_CYC)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .expired_o  (expired)
  );

  ddr_init_fsm #(
    .T_RP(T_RP), .T_MRD(T_MRD), .T_RFC(T_RFC), .T_FINAL(T_FINAL),
    .N_REF(N_REF), .CNT_W(CNT_W)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .expired_i  (expired),
    .step_o     (step),
    .in_cmd_o   (in_cmd),
    .load_o     (load),
    .load_val_o (load_val),
    .done_o     (done_o)
  );

  ddr_init_cmd_enc #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_enc (
    .step_i       (step),
    .in_cmd_i     (in_cmd),
    .burst_len_i  (burst_len_i),
    .burst_type_i (burst_type_i),
    .cas_lat_i    (cas_lat_i),
    .ext_mode_i   (ext_mode_i),
    .pins_o       (pins),
    .ba_o         (ba_o),
    .addr_o       (addr_o)
  );

  assign cke_o  = cke_q;
  assign cs_no  = pins.cs_n;
  assign ras_no = pins.ras_n;
  assign cas_no = pins.cas_n;
  assign we_no  = pins.we_n;

  logic bus_nop;
  assign bus_nop = (pins == PINS_NOP);

  a_r2_cmd_needs_cke: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_nop |-> cke_o);

  a_r3_cmd_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_nop |=> bus_nop);

  a_r10_done_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (bus_nop && cke_o && addr_o == '0));

endmodule

// File: tb/ddr_init_seq_test.sv
module ddr_init_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int S      = 6;
  localparam int TRP    = 2;
  localparam int TMRD   = 3;
  localparam int TRFC   = 4;
  localparam int TFIN   = 5;
  localparam int NREF   = 3;
  localparam int AW     = 13;
  localparam int TRACE  = 64;

  // trace codes
  localparam int C_NOP = 0, C_PRE1 = 1, C_EMRS = 2, C_MDLL = 3,
                 C_PRE2 = 4, C_REF = 5, C_MFIN = 6, C_DONE = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] bl = '0;
  logic bt = 1'b0;
  logic [2:0] cl = '0;
  logic [AW-2:0] ext = '0;
  logic cke, cs_n, ras_n, cas_n, we_n, done;
  logic [1:0] ba;
  logic [AW-1:0] addr;

  int total = 0;
  int bad = 0;
  int code_at[TRACE];
  int done_at;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr_init_seq #(
    .STABLE_CYC(S), .T_RP(TRP), .T_MRD(TMRD), .T_RFC(TRFC),
    .T_FINAL(TFIN), .N_REF(NREF), .ADDR_W(AW), .BA_W(2)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .burst_len_i(bl), .burst_type_i(bt),
    .cas_lat_i(cl), .ext_mode_i(ext), .cke_o(cke), .cs_no(cs_n),
    .ras_no(ras_n), .cas_no(cas_n), .we_no(we_n), .ba_o(ba),
    .addr_o(addr), .done_o(done)
  );

  task automatic build_trace();
    int p;
    for (int i = 0; i < TRACE; i++) code_at[i] = C_NOP;
    p = S + 1;
    code_at[p] = C_PRE1; p += TRP + 1;
    code_at[p] = C_EMRS; p += TMRD + 1;
    code_at[p] = C_MDLL; p += TMRD + 1;
    code_at[p] = C_PRE2; p += TRP + 1;
    for (int r = 0; r < NREF; r++) begin
      code_at[p] = C_REF; p += TRFC + 1;
    end
    code_at[p] = C_MFIN; p += TFIN + 1;
    done_at = p;
    for (int i = p; i < TRACE; i++) code_at[i] = C_DONE;
  endtask

  // {cke, done, cs, ras, cas, we, ba, addr}
  function automatic logic [20:0] expect_of(int code, logic cke_e);
    logic [3:0] pins;
    logic [1:0] eba;
    logic [AW-1:0] ea;
    logic ed;
    pins = 4'b0111; eba = '0; ea = '0; ed = 1'b0;
    case (code)
      C_PRE1, C_PRE2: begin pins = 4'b0010; ea = 13'h400; end
      C_EMRS: begin pins = 4'b0000; eba = 2'b01; ea = {ext, 1'b0}; end
      C_MDLL: begin pins = 4'b0000; ea = {4'b0, 1'b1, 1'b0, cl, bt, bl}; end
      C_MFIN: begin pins = 4'b0000; ea = {4'b0, 1'b0, 1'b0, cl, bt, bl}; end
      C_REF:  pins = 4'b0001;
      C_DONE: ed = 1'b1;
      default: ;
    endcase
    return {cke_e, ed, pins, eba, ea};
  endfunction

  function automatic string req_of(int code, int t);
    case (code)
      C_PRE1: return "R4";
      C_EMRS: return "R5";
      C_MDLL: return "R6";
      C_PRE2: return "R7";
      C_REF:  return "R8";
      C_MFIN: return "R9";
      C_DONE: return (t == done_at) ? "R9" : "R10";
      default: return (t <= S) ? "R2" : "R3";
    endcase
  endfunction

  task automatic check(string req, logic [20:0] act, logic [20:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s t=%0t actual=%h expected=%h", req, $time, act, exp);
    end
  endtask

  function automatic logic [20:0] bus_now();
    return {cke, done, cs_n, ras_n, cas_n, we_n, ba, addr};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1", bus_now(), expect_of(C_NOP, 1'b0));
    @(negedge clk);
    check("R1", bus_now(), expect_of(C_NOP, 1'b0));
    rst_n = 1'b1;
  endtask

  // run cycles 1..n after release, compare each against the trace
  task automatic run_trace(int n);
    for (int t = 1; t <= n; t++) begin
      @(negedge clk);
      check(req_of(code_at[t], t), bus_now(), expect_of(code_at[t], 1'b1));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    build_trace();
    // sweep of mode patterns; ext low bit always set to expose A0 forcing (R5)
    for (int pat = 0; pat < 8; pat++) begin
      bl  = 3'(pat);
      bt  = pat[0] ^ pat[2];
      cl  = 3'((pat * 3 + 1) % 8);
      ext = 12'((pat * 12'h2D5) ^ 12'hA5B) | 12'h001;
      do_reset();
      run_trace(done_at + 3);
    end
    // R10: a mid-sequence reset restarts from the reset state
    bl = 3'd3; bt = 1'b1; cl = 3'd2; ext = 12'h7E1;
    do_reset();
    run_trace(done_at - 4);
    do_reset();
    run_trace(TRACE - 1);
    // R10: done and idle bus persist
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      check("R10", bus_now(), expect_of(C_DONE, 1'b1));
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule